// File: doc/BRIEF.md
# Bidirectional Strobed Port Controller

This block runs the handshake for one parallel data port that carries traffic both ways between a CPU and a peripheral over a single set of pins. The CPU side gives it active-low read and write strobes aimed at the port, plus the write data. The peripheral side gives it an active-low strobe, which loads the pins into an input latch, and an active-low acknowledge, which turns on the output drivers. The block answers with an active-low output-buffer-full flag, an input-buffer-full flag, a single interrupt request, a pin output-enable, both data latches, and a status byte that the CPU can read back.

Two interrupt-enable flags decide whether each event source may raise the request. One flag covers the outbound (acknowledge) side and the other covers the inbound (strobe) side. They are loaded from a bit set/reset command, which names a bit index and a value. A mode write is a pulse that returns every flag, enable and latch to its idle state. All inputs are sampled on the block clock. Edges are found by comparing each input with the value it had one cycle earlier. Every registered output moves one clock after the sampled edge or level that causes it.

Top module: `bidir_strobe_port`

## Requirements
- R1: On a sampled rising edge of `cpu_wr_n_i`, the output latch takes `cpu_wdata_i`. `pin_o` shows the output latch at all times and is all zeros after reset.
- R2: `obf_n_o` goes low one clock after a rising edge of `cpu_wr_n_i`. It returns high one clock after any cycle in which `pack_n_i` is low and no write rising edge is sampled. If both happen in the same cycle, the write wins and the flag goes low.
- R3: `pin_oe_o` is high exactly while `pack_n_i` is low, in the same cycle, with no register in between.
- R4: In every cycle where `pstb_n_i` is low, `rdata_o` takes `pin_i` and `ibf_o` goes high one clock later. A rising edge of `cpu_rd_n_i` clears `ibf_o` one clock later, unless the strobe is low in that same cycle.
- R5: A rising edge of `pack_n_i` makes `intr_o` high one clock later when the outbound enable is 1. A rising edge of `pstb_n_i` does the same when the inbound enable is 1. A source whose enable is 0 raises nothing. The enable value used is the one held before any set/reset command in the same cycle.
- R6: An acknowledge-raised request is cleared only by a falling edge of `cpu_wr_n_i`. A strobe-raised request is cleared only by a falling edge of `cpu_rd_n_i`. `intr_o` is the OR of the two, so when both are pending it needs one write fall and one read fall, in either order. A set edge wins over a clear edge in the same cycle.
- R7: When `bsr_valid_i` is high, index 6 loads the outbound enable and index 4 loads the inbound enable from `bsr_val_i`. Any other index leaves both enables unchanged.
- R8: `status_o` bit 7 is `obf_n_o`, bit 6 the outbound enable, bit 5 `ibf_o`, bit 4 the inbound enable, bit 3 `intr_o`. Bits 2:0 pass `other_stat_i` straight through.
- R9: Reset, or a clock with `mode_wr_i` high, sets `obf_n_o` high and clears `ibf_o`, both pending requests, both enables and both data latches. A mode write overrides every other input in that cycle.
- R10: Clearing an enable does not cancel a request that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| mode_wr_i | input | 1 | Mode write pulse; clears all handshake state |
| bsr_valid_i | input | 1 | Bit set/reset command valid |
| bsr_idx_i | input | $clog2(W) | Bit index of the set/reset command |
| bsr_val_i | input | 1 | Value written by the set/reset command |
| cpu_wr_n_i | input | 1 | CPU write strobe for this port, active low |
| cpu_rd_n_i | input | 1 | CPU read strobe for this port, active low |
| cpu_wdata_i | input | W | CPU write data |
| pstb_n_i | input | 1 | Peripheral strobe, active low |
| pack_n_i | input | 1 | Peripheral acknowledge, active low |
| pin_i | input | W | Value seen on the port pins |
| other_stat_i | input | W-5 | Status bits from the other group |
| pin_o | output | W | Output latch, to the pin drivers |
| pin_oe_o | output | 1 | Pin driver enable |
| rdata_o | output | W | Input latch |
| obf_n_o | output | 1 | Output buffer full, active low |
| ibf_o | output | 1 | Input buffer full |
| intr_o | output | 1 | Interrupt request |
| status_o | output | W | Status byte for readback |

## Verification
The bench goes after the cases where two events meet in one cycle. A write edge together with a low acknowledge must leave the buffer full; a design that gives the acknowledge priority drops the word without the peripheral ever taking it. A strobe together with a read edge must leave the input flag set; getting this wrong loses a byte the CPU has not read. The bench holds both interrupt sources pending and then removes them one at a time. A design with a single request flag would drop the request after only one of the two falls. The bench also clears an enable while a request is pending, writes set/reset commands to indices that should do nothing, and issues mode writes in the middle of traffic. A wrong priority or a decode that is off by one shows up there as a wrong status byte.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  // status byte positions (readback layout is fixed by software)
  localparam int unsigned ST_OBF   = 7;
  localparam int unsigned ST_INTEO = 6;
  localparam int unsigned ST_IBF   = 5;
  localparam int unsigned ST_INTEI = 4;
  localparam int unsigned ST_INTR  = 3;
  localparam int unsigned ST_FLAGS = 5;

  // edge detector lane assignment
  localparam int unsigned E_WR  = 0;
  localparam int unsigned E_RD  = 1;
  localparam int unsigned E_STB = 2;
  localparam int unsigned E_ACK = 3;
  localparam int unsigned E_N   = 4;

  typedef struct packed {
    logic obf_n;
    logic inte_out;
    logic ibf;
    logic inte_in;
    logic intr;
  } hs_flags_t;
endpackage

// File: rtl/bsp_edge_det.sv
module bsp_edge_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  // per-lane history; idle level of every strobe is high
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q;
    assign fall_o[g] = ~sig_i[g] & prev_q;
  end
endmodule

// File: rtl/bsp_inte_regs.sv
module bsp_inte_regs #(
  parameter int unsigned W        = 8,
  parameter int unsigned POS_OUT  = 6,
  parameter int unsigned POS_IN   = 4,
  localparam int unsigned IDX_W   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             bsr_valid_i,
  input  logic [IDX_W-1:0] bsr_idx_i,
  input  logic             bsr_val_i,
  output logic             inte_out_o,
  output logic             inte_in_o
);
  logic hit_out, hit_in;
  logic out_d, in_d, out_q, in_q;
  logic out_en, in_en;

  assign hit_out = bsr_valid_i && (bsr_idx_i == IDX_W'(POS_OUT));
  assign hit_in  = bsr_valid_i && (bsr_idx_i == IDX_W'(POS_IN));

  always_comb begin
    out_en = clr_i | hit_out;
    in_en  = clr_i | hit_in;
    out_d  = clr_i ? 1'b0 : bsr_val_i;
    in_d   = clr_i ? 1'b0 : bsr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      in_q  <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      if (in_en)  in_q  <= in_d;
    end
  end

  assign inte_out_o = out_q;
  assign inte_in_o  = in_q;
endmodule

// File: rtl/bsp_tx_side.sv
module bsp_tx_side #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic         ack_n_i,
  input  logic         ack_rise_i,
  input  logic         inte_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] olat_o,
  output logic         obf_n_o,
  output logic         pend_o
);
  logic [W-1:0] olat_d, olat_q;
  logic         obf_n_d, obf_n_q;
  logic         pend_d, pend_q;
  logic         olat_en;

  always_comb begin
    olat_en = clr_i | wr_rise_i;
    olat_d  = clr_i ? '0 : wdata_i;
    obf_n_d = obf_n_q;
    pend_d  = pend_q;
    if (clr_i) begin
      obf_n_d = 1'b1;
      pend_d  = 1'b0;
    end else begin
      // new word beats a concurrent acknowledge
      if (wr_rise_i)     obf_n_d = 1'b0;
      else if (!ack_n_i) obf_n_d = 1'b1;
      if (ack_rise_i && inte_i) pend_d = 1'b1;
      else if (wr_fall_i)       pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olat_q  <= '0;
      obf_n_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (olat_en) olat_q <= olat_d;
      obf_n_q <= obf_n_d;
      pend_q  <= pend_d;
    end
  end

  assign olat_o  = olat_q;
  assign obf_n_o = obf_n_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/bsp_rx_side.sv
module bsp_rx_side #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         stb_n_i,
  input  logic         stb_rise_i,
  input  logic         rd_rise_i,
  input  logic         rd_fall_i,
  input  logic         inte_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] ilat_o,
  output logic         ibf_o,
  output logic         pend_o
);
  logic [W-1:0] ilat_d, ilat_q;
  logic         ibf_d, ibf_q;
  logic         pend_d, pend_q;
  logic         ilat_en;

  always_comb begin
    ilat_en = clr_i | ~stb_n_i;
    ilat_d  = clr_i ? '0 : pin_i;
    ibf_d   = ibf_q;
    pend_d  = pend_q;
    if (clr_i) begin
      ibf_d  = 1'b0;
      pend_d = 1'b0;
    end else begin
      // a live strobe keeps the buffer full over a read edge
      if (!stb_n_i)       ibf_d = 1'b1;
      else if (rd_rise_i) ibf_d = 1'b0;
      if (stb_rise_i && inte_i) pend_d = 1'b1;
      else if (rd_fall_i)       pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilat_q <= '0;
      ibf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ilat_en) ilat_q <= ilat_d;
      ibf_q  <= ibf_d;
      pend_q <= pend_d;
    end
  end

  assign ilat_o = ilat_q;
  assign ibf_o  = ibf_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/bidir_strobe_port.sv
module bidir_strobe_port
  import bsp_pkg::*;
#(
  parameter int unsigned W            = 8,
  parameter int unsigned INTE_OUT_POS = 6,
  parameter int unsigned INTE_IN_POS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr_i,
  input  logic                  bsr_valid_i,
  input  logic [$clog2(W)-1:0]  bsr_idx_i,
  input  logic                  bsr_val_i,
  input  logic                  cpu_wr_n_i,
  input  logic                  cpu_rd_n_i,
  input  logic [W-1:0]          cpu_wdata_i,
  input  logic                  pstb_n_i,
  input  logic                  pack_n_i,
  input  logic [W-1:0]          pin_i,
  input  logic [W-ST_FLAGS-1:0] other_stat_i,
  output logic [W-1:0]          pin_o,
  output logic                  pin_oe_o,
  output logic [W-1:0]          rdata_o,
  output logic                  obf_n_o,
  output logic                  ibf_o,
  output logic                  intr_o,
  output logic [W-1:0]          status_o
);
  localparam int unsigned OTHER_W = W - ST_FLAGS;

  logic [E_N-1:0] lanes, rise, fall;
  logic           inte_out, inte_in;
  logic           pend_ack, pend_stb;
  hs_flags_t      flags;

  always_comb begin
    lanes        = '1;
    lanes[E_WR]  = cpu_wr_n_i;
    lanes[E_RD]  = cpu_rd_n_i;
    lanes[E_STB] = pstb_n_i;
    lanes[E_ACK] = pack_n_i;
  end

  bsp_edge_det #(.N(E_N)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (lanes),
    .rise_o (rise),
    .fall_o (fall)
  );

  bsp_inte_regs #(.W(W), .POS_OUT(INTE_OUT_POS), .POS_IN(INTE_IN_POS)) u_inte (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (mode_wr_i),
    .bsr_valid_i (bsr_valid_i),
    .bsr_idx_i   (bsr_idx_i),
    .bsr_val_i   (bsr_val_i),
    .inte_out_o  (inte_out),
    .inte_in_o   (inte_in)
  );

  bsp_tx_side #(.W(W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (mode_wr_i),
    .wr_rise_i  (rise[E_WR]),
    .wr_fall_i  (fall[E_WR]),
    .ack_n_i    (pack_n_i),
    .ack_rise_i (rise[E_ACK]),
    .inte_i     (inte_out),
    .wdata_i    (cpu_wdata_i),
    .olat_o     (pin_o),
    .obf_n_o    (obf_n_o),
    .pend_o     (pend_ack)
  );

  bsp_rx_side #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (mode_wr_i),
    .stb_n_i    (pstb_n_i),
    .stb_rise_i (rise[E_STB]),
    .rd_rise_i  (rise[E_RD]),
    .rd_fall_i  (fall[E_RD]),
    .inte_i     (inte_in),
    .pin_i      (pin_i),
    .ilat_o     (rdata_o),
    .ibf_o      (ibf_o),
    .pend_o     (pend_stb)
  );

  assign pin_oe_o = ~pack_n_i;
  assign intr_o   = pend_ack | pend_stb;

  always_comb begin
    flags.obf_n    = obf_n_o;
    flags.inte_out = inte_out;
    flags.ibf      = ibf_o;
    flags.inte_in  = inte_in;
    flags.intr     = intr_o;
  end

  if (OTHER_W > 0) begin : g_other
    assign status_o = {flags, other_stat_i};
  end else begin : g_noother
    assign status_o = flags;
  end
endmodule

// File: rtl/bidir_strobe_port_chk.sv
module bidir_strobe_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_wr_i,
  input logic         cpu_wr_n_i,
  input logic         cpu_rd_n_i,
  input logic         pstb_n_i,
  input logic         pack_n_i,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] rdata_o,
  input logic         obf_n_o,
  input logic         ibf_o,
  input logic         intr_o,
  input logic [W-1:0] status_o
);
  p_obf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_wr_n_i) && !mode_wr_i) |=> !obf_n_o);

  p_obf_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pack_n_i && !$rose(cpu_wr_n_i)) |=> obf_n_o);

  p_pin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pack_n_i && $stable(cpu_wr_n_i) && !mode_wr_i) |=> $stable(pin_o));

  p_ibf_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n_i && !mode_wr_i) |=> (ibf_o && rdata_o == $past(pin_i)));

  p_ibf_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_rd_n_i) && pstb_n_i) |=> !ibf_o);

  p_ack_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pack_n_i) && status_o[6] && !mode_wr_i) |=> intr_o);

  p_intr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_o && $stable(cpu_wr_n_i) && $stable(cpu_rd_n_i) && !mode_wr_i) |=> intr_o);

  p_status_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] == obf_n_o) && (status_o[5] == ibf_o) && (status_o[3] == intr_o));

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (obf_n_o && !ibf_o && !intr_o && !status_o[6] && !status_o[4]));
endmodule

bind bidir_strobe_port bidir_strobe_port_chk #(.W(W)) chk_i (.*);

// File: tb/bidir_strobe_port_tb_top.sv
`timescale 1ns/1ps
module bidir_strobe_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_wr, bsr_v, bsr_val;
  logic [2:0] bsr_idx;
  logic wr_n, rd_n, stb_n, ack_n;
  logic [W-1:0] wdata, pins;
  logic [2:0] oth;
  logic [W-1:0] pin_o, rdata, status;
  logic pin_oe, obf_n, ibf, intr;

  always #2.5 clk = ~clk;

  bidir_strobe_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .bsr_valid_i(bsr_v),
    .bsr_idx_i(bsr_idx), .bsr_val_i(bsr_val), .cpu_wr_n_i(wr_n), .cpu_rd_n_i(rd_n),
    .cpu_wdata_i(wdata), .pstb_n_i(stb_n), .pack_n_i(ack_n), .pin_i(pins),
    .other_stat_i(oth), .pin_o(pin_o), .pin_oe_o(pin_oe), .rdata_o(rdata),
    .obf_n_o(obf_n), .ibf_o(ibf), .intr_o(intr), .status_o(status)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic m_obf_n, m_ibf, m_eo, m_ei, m_pa, m_ps;
  logic [W-1:0] m_olat, m_ilat;
  logic p_wr, p_rd, p_stb, p_ack;

  task automatic chk(input string req, input string note, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, note, act, exp);
    end
  endtask

  task automatic model_reset();
    m_obf_n = 1; m_ibf = 0; m_eo = 0; m_ei = 0; m_pa = 0; m_ps = 0;
    m_olat = '0; m_ilat = '0;
    p_wr = 1; p_rd = 1; p_stb = 1; p_ack = 1;
  endtask

  task automatic check_all(input string note);
    logic m_intr;
    m_intr = m_pa | m_ps;
    chk("R1 output latch", note, 32'(pin_o), 32'(m_olat));
    chk("R2 obf", note, 32'(obf_n), 32'(m_obf_n));
    chk("R3 pin enable", note, 32'(pin_oe), 32'(!ack_n));
    chk("R4 ibf", note, 32'(ibf), 32'(m_ibf));
    chk("R4 input latch", note, 32'(rdata), 32'(m_ilat));
    chk("R5 R6 intr", note, 32'(intr), 32'(m_intr));
    chk("R8 status", note, 32'(status), 32'({m_obf_n, m_eo, m_ibf, m_ei, m_intr, oth}));
  endtask

  // inputs are already driven (called at a falling edge)
  task automatic step(input string note);
    logic wr_r, wr_f, rd_r, rd_f, stb_r, ack_r, eo_old, ei_old;
    @(posedge clk);
    wr_r = wr_n & ~p_wr;  wr_f = ~wr_n & p_wr;
    rd_r = rd_n & ~p_rd;  rd_f = ~rd_n & p_rd;
    stb_r = stb_n & ~p_stb; ack_r = ack_n & ~p_ack;
    eo_old = m_eo; ei_old = m_ei;
    if (mode_wr) begin
      m_obf_n = 1; m_ibf = 0; m_eo = 0; m_ei = 0; m_pa = 0; m_ps = 0;
      m_olat = '0; m_ilat = '0;
    end else begin
      if (bsr_v && bsr_idx == 3'd6) m_eo = bsr_val;
      if (bsr_v && bsr_idx == 3'd4) m_ei = bsr_val;
      if (wr_r) begin m_olat = wdata; m_obf_n = 0; end
      else if (!ack_n) m_obf_n = 1;
      if (!stb_n) begin m_ilat = pins; m_ibf = 1; end
      else if (rd_r) m_ibf = 0;
      if (ack_r && eo_old) m_pa = 1; else if (wr_f) m_pa = 0;
      if (stb_r && ei_old) m_ps = 1; else if (rd_f) m_ps = 0;
    end
    p_wr = wr_n; p_rd = rd_n; p_stb = stb_n; p_ack = ack_n;
    @(negedge clk);
    check_all(note);
    mode_wr = 0; bsr_v = 0;
  endtask

  task automatic bsr(input logic [2:0] idx, input logic v, input string note);
    bsr_v = 1; bsr_idx = idx; bsr_val = v;
    step(note);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; mode_wr = 0; bsr_v = 0; bsr_idx = 0; bsr_val = 0;
    wr_n = 1; rd_n = 1; stb_n = 1; ack_n = 1; wdata = '0; pins = '0; oth = 3'b101;
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R9 reset state");
    rst_n = 1;
    @(negedge clk);
    check_all("R9 after release");

    // R1 R2 R3: write then acknowledge
    wdata = 8'hA5; wr_n = 0; step("write low");
    wr_n = 1; step("R1 R2 write rise");
    wdata = 8'h00; ack_n = 0; step("R3 ack low drives pins");
    ack_n = 1; step("ack release");
    // R4: strobe, then read
    pins = 8'h3C; stb_n = 0; step("R4 strobe low");
    pins = 8'h77; step("R4 strobe held, latch follows");
    stb_n = 1; pins = 8'h11; step("R4 strobe high, latch holds");
    rd_n = 0; step("read low");
    rd_n = 1; step("R4 read rise clears ibf");
    // R7: enables through set/reset, stray indices ignored
    bsr(3'd6, 1, "R7 set outbound enable");
    bsr(3'd5, 0, "R7 stray index 5");
    bsr(3'd7, 0, "R7 stray index 7");
    bsr(3'd4, 1, "R7 set inbound enable");
    bsr(3'd0, 0, "R7 stray index 0");
    // R5 R6: both sources pending, removed one at a time
    ack_n = 0; step("ack low");
    ack_n = 1; step("R5 ack rise raises intr");
    stb_n = 0; pins = 8'h5A; step("strobe low");
    stb_n = 1; step("R5 strobe rise raises intr");
    wr_n = 0; wdata = 8'hC3; step("R6 write fall clears ack source only");
    wr_n = 1; step("write rise");
    rd_n = 0; step("R6 read fall clears strobe source");
    rd_n = 1; step("read rise");
    // R10: clearing enable keeps pending request
    ack_n = 0; step("ack low");
    ack_n = 1; step("ack rise");
    bsr(3'd6, 0, "R10 clear enable, request stays");
    ack_n = 0; step("ack low disabled");
    ack_n = 1; step("R5 ack rise with enable off");
    wr_n = 0; step("R6 write fall clears");
    wr_n = 1; step("write rise");
    bsr(3'd4, 0, "R7 clear inbound enable");
    stb_n = 0; step("strobe low");
    stb_n = 1; step("R5 strobe rise with enable off");
    // R2: write rise with acknowledge low, write wins
    ack_n = 0; wr_n = 0; step("ack and write low");
    wr_n = 1; wdata = 8'h96; step("R2 write rise with ack low");
    step("R2 ack low empties buffer");
    ack_n = 1; step("ack release");
    // R4: read rise with strobe low, strobe wins
    rd_n = 0; step("read low");
    rd_n = 1; stb_n = 0; pins = 8'hE1; step("R4 read rise with strobe low");
    stb_n = 1; step("strobe release");
    // R9: mode write mid traffic
    bsr(3'd6, 1, "set enable");
    ack_n = 0; step("ack low");
    ack_n = 1; mode_wr = 1; step("R9 mode write beats ack rise");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) wr_n = ~wr_n;
      if ($urandom_range(0, 3) == 0) rd_n = ~rd_n;
      if ($urandom_range(0, 3) == 0) stb_n = ~stb_n;
      if ($urandom_range(0, 3) == 0) ack_n = ~ack_n;
      wdata = 8'($urandom);
      pins = 8'($urandom);
      oth = 3'($urandom);
      mode_wr = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 5) == 0) begin
        bsr_v = 1; bsr_idx = 3'($urandom); bsr_val = 1'($urandom);
      end
      step("random R1 R2 R4 R5 R6 R7 R9");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule